// File: doc/BRIEF.md
# Static Wear-Leveling Trigger

This block sits beside a flash block allocator and decides when data that is rarely rewritten ("cold" data) has to be moved, so that blocks holding it also take their share of erases. Physical blocks are grouped into sets of `2^SET_SHIFT` neighbours. Each set has one bit in a coarse table. The bit records whether any block of that set has been erased since the table was last cleared. Next to the table the block keeps two counters: the erases seen, and the sets whose bit is set.

Each erase notification names one physical block. The notification marks that block's set and bumps the erase counter. When the erase counter reaches `THRESH` times the marked-set count, the block looks for a set that is still unmarked. It raises a clean request naming that set. The cleaner then relocates the live data, erases the set and updates the mapping, and the block waits for it to report completion. If the ratio is met while every set is already marked, nothing useful is left to pick. In that case the table and both counters are wiped, and the search pointer jumps to a pseudo-random set.

Top module: `wear_level_trigger`

## Requirements
- R1: After reset `clean_req` is low, the table is empty, both counters are zero and the search pointer is set 0.
- R2: An erase notification for block b marks set b >> SET_SHIFT (the upper bits of `erase_block`). The marked-set count rises by one only when that set was unmarked before.
- R3: Every erase notification adds one to the erase counter. The counter saturates at its all-ones value.
- R4: A trigger fires in a cycle when no request is outstanding, the marked-set count is non-zero and the erase counter is at least THRESH times the marked-set count. The test uses the state held before that cycle's notification. When the trigger selects a set, `clean_req` rises at the next clock edge.
- R5: The selected set is the first unmarked set found by stepping upward from the search pointer, wrapping from the last set to set 0. After selection the pointer moves to the selected set plus one, modulo the set count.
- R6: Only one request is outstanding at a time. `clean_req` stays high and `clean_set` stays stable until `clean_done` is sampled high. No new request can begin in the cycle that `clean_done` is seen. A trigger can fire again from the following cycle.
- R7: A trigger that finds every set marked raises no request. It clears all marks and both counters, and loads the search pointer from the low set-index bits of the random generator. A notification in that same cycle is counted into the cleared table, leaving one mark, a marked-set count of one and an erase counter of one.
- R8: The random generator is a 16-bit shift register. Its reset value is 0xACE1, and it steps on every clock edge out of reset as next = {g[14:0], g[15]^g[13]^g[12]^g[10]}. Its value before the step is the one used by R7.
- R9: While the marked-set count is zero, no trigger fires, whatever the erase counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_valid | input | 1 | One erase notification this cycle |
| erase_block | input | BLK_W | Physical block that was erased |
| clean_done | input | 1 | Cleaner finished the outstanding request |
| clean_req | output | 1 | Clean request outstanding |
| clean_set | output | SET_W | Set index the cleaner must relocate |

## Verification
The hardest case to reach from the ports is the table wipe. It needs every set marked while the ratio is met, and each earlier trigger has already pointed the cleaner at a still-unmarked set. The bench makes this common by using a small threshold and only four sets. It also answers requests with a random delay, so erases pile up while a request is outstanding. A cycle-accurate model in the bench, which includes its own copy of the random generator, predicts the request and the chosen set on every cycle. The model counts wipes and selections, so the bench can confirm that both paths occurred.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int RNG_W = 16;
  localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] g);
    return {g[14:0], g[15] ^ g[13] ^ g[12] ^ g[10]};
  endfunction
endpackage

// File: rtl/wl_flag_table.sv
module wl_flag_table #(
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2,
  parameter int CNT_W    = 16,
  parameter int FC_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [SET_W-1:0]    ev_set,
  input  logic                wipe,
  output logic [NUM_SETS-1:0] flags_q,
  output logic [CNT_W-1:0]    erase_cnt,
  output logic [FC_W-1:0]     flag_cnt
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  logic [NUM_SETS-1:0] base_flags, next_flags;
  logic [CNT_W-1:0]    base_ec, next_ec;
  logic [FC_W-1:0]     base_fc, next_fc;
  logic                first_mark;

  always_comb begin
    base_flags = wipe ? '0 : flags_q;
    base_ec    = wipe ? '0 : erase_cnt;
    base_fc    = wipe ? '0 : flag_cnt;
    first_mark = ev_valid && !base_flags[ev_set];
    next_flags = base_flags;
    next_ec    = base_ec;
    next_fc    = base_fc;
    if (ev_valid) begin
      next_flags[ev_set] = 1'b1;
      next_ec            = sat_inc(base_ec);
    end
    if (first_mark) next_fc = base_fc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      erase_cnt <= '0;
      flag_cnt  <= '0;
    end else begin
      flags_q   <= next_flags;
      erase_cnt <= next_ec;
      flag_cnt  <= next_fc;
    end
  end

  assert_flag_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_cnt == FC_W'($countones(flags_q)));

  assert_erase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !wipe && erase_cnt != '1) |=> erase_cnt == $past(erase_cnt) + 1'b1);

  assert_wipe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (erase_cnt <= 1 && flag_cnt <= 1));
endmodule

// File: rtl/wl_ratio_check.sv
module wl_ratio_check #(
  parameter int CNT_W  = 16,
  parameter int FC_W   = 3,
  parameter int THRESH = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] erase_cnt,
  input  logic [FC_W-1:0]  flag_cnt,
  output logic             ratio_met
);
  localparam int PROD_W = CNT_W + FC_W + 1;

  function automatic logic [PROD_W-1:0] scaled_limit(input logic [FC_W-1:0] fc);
    return PROD_W'(THRESH) * PROD_W'(fc);
  endfunction

  assign ratio_met = (flag_cnt != '0) && (PROD_W'(erase_cnt) >= scaled_limit(flag_cnt));

  assert_zero_flags_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cnt == '0) |-> !ratio_met);
endmodule

// File: rtl/wl_set_picker.sv
module wl_set_picker #(
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SETS-1:0] flags,
  input  logic                advance,
  input  logic                reseed,
  output logic [SET_W-1:0]    pick_idx,
  output logic                all_set
);
  import wl_pkg::*;

  logic [SET_W-1:0] ptr_q;
  logic [RNG_W-1:0] rng_q;

  function automatic logic [SET_W-1:0] find_clear(input logic [NUM_SETS-1:0] f,
                                                  input logic [SET_W-1:0] start);
    logic [SET_W-1:0] res;
    logic             found;
    res   = start;
    found = 1'b0;
    for (int i = 0; i < NUM_SETS; i++) begin
      logic [SET_W-1:0] idx;
      idx = SET_W'((int'(start) + i) % NUM_SETS);
      if (!found && !f[idx]) begin
        res   = idx;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  assign all_set  = &flags;
  assign pick_idx = find_clear(flags, ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rng_q <= RNG_SEED;
    end else begin
      rng_q <= rng_step(rng_q);
      if (reseed)       ptr_q <= SET_W'(int'(rng_q[SET_W-1:0]) % NUM_SETS);
      else if (advance) ptr_q <= SET_W'((int'(pick_idx) + 1) % NUM_SETS);
    end
  end

  assert_pick_is_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !flags[pick_idx]);

  assert_pointer_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !reseed) |=> ptr_q == SET_W'((int'($past(pick_idx)) + 1) % NUM_SETS));

  assert_rng_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rng_q != '0);
endmodule

// File: rtl/wear_level_trigger.sv
module wear_level_trigger #(
  parameter int NUM_BLOCKS = 16,
  parameter int SET_SHIFT  = 2,
  parameter int THRESH     = 1000,
  parameter int CNT_W      = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int SET_W     = BLK_W - SET_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_valid,
  input  logic [BLK_W-1:0] erase_block,
  input  logic             clean_done,
  output logic             clean_req,
  output logic [SET_W-1:0] clean_set
);
  localparam int NUM_SETS = NUM_BLOCKS >> SET_SHIFT;
  localparam int FC_W     = $clog2(NUM_SETS + 1);

  logic [NUM_SETS-1:0] flags;
  logic [CNT_W-1:0]    erase_cnt;
  logic [FC_W-1:0]     flag_cnt;
  logic                ratio_met, all_set, trig, issue, wipe;
  logic [SET_W-1:0]    pick_idx, ev_set;
  logic                pend_q;
  logic [SET_W-1:0]    set_q;

  assign ev_set = erase_block[BLK_W-1:SET_SHIFT];
  assign trig   = !pend_q && ratio_met;
  assign issue  = trig && !all_set;
  assign wipe   = trig && all_set;

  wl_flag_table #(.NUM_SETS(NUM_SETS), .SET_W(SET_W), .CNT_W(CNT_W), .FC_W(FC_W)) u_table (
    .clk(clk), .rst_n(rst_n), .ev_valid(erase_valid), .ev_set(ev_set), .wipe(wipe),
    .flags_q(flags), .erase_cnt(erase_cnt), .flag_cnt(flag_cnt));

  wl_ratio_check #(.CNT_W(CNT_W), .FC_W(FC_W), .THRESH(THRESH)) u_ratio (
    .clk(clk), .rst_n(rst_n), .erase_cnt(erase_cnt), .flag_cnt(flag_cnt),
    .ratio_met(ratio_met));

  wl_set_picker #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .flags(flags), .advance(issue), .reseed(wipe),
    .pick_idx(pick_idx), .all_set(all_set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      set_q  <= '0;
    end else if (issue) begin
      pend_q <= 1'b1;
      set_q  <= pick_idx;
    end else if (clean_done) begin
      pend_q <= 1'b0;
    end
  end

  assign clean_req = pend_q;
  assign clean_set = set_q;

  assert_request_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_req && !clean_done) |=> (clean_req && $stable(clean_set)));

  assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_req && clean_done) |=> !clean_req);

  assert_request_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clean_req) |-> $past(ratio_met));

  assert_wipe_no_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clean_req && all_set && ratio_met) |=> !clean_req);
endmodule

// File: tb/test_wear_level_trigger.sv
module test_wear_level_trigger;
  localparam int NB = 16, SH = 2, TH = 4, NS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       erase_valid = 1'b0;
  logic [3:0] erase_block = '0;
  logic       clean_done = 1'b0;
  logic       clean_req;
  logic [1:0] clean_set;

  int checks = 0, failures = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  wear_level_trigger #(.NUM_BLOCKS(NB), .SET_SHIFT(SH), .THRESH(TH), .CNT_W(16)) i_wear_level_trigger (
    .clk(clk), .rst_n(rst_n), .erase_valid(erase_valid), .erase_block(erase_block),
    .clean_done(clean_done), .clean_req(clean_req), .clean_set(clean_set));

  // bench-side model of the requirements
  bit          mflag [NS];
  int          mec, mfc, mset, mptr, nwipe, nissue;
  bit          mpend;
  logic [15:0] mrng;

  function automatic int first_free(int start);
    for (int i = 0; i < NS; i++) if (!mflag[(start + i) % NS]) return (start + i) % NS;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mflag[i]) mflag[i] = 0;
      mec = 0; mfc = 0; mpend = 0; mset = 0; mptr = 0; mrng = 16'hACE1;
    end else begin
      bit fire;
      fire = !mpend && mfc > 0 && mec >= TH * mfc;
      if (fire && mfc == NS) begin            // R7 wipe
        foreach (mflag[i]) mflag[i] = 0;
        mec = 0; mfc = 0; mptr = mrng[1:0]; nwipe++;
      end else if (fire) begin                // R5 selection
        mset = first_free(mptr); mptr = (mset + 1) % NS; mpend = 1; nissue++;
      end else if (clean_done && mpend) mpend = 0;
      if (erase_valid) begin                  // R2 / R3
        if (!mflag[erase_block >> SH]) mfc++;
        mflag[erase_block >> SH] = 1;
        if (mec < 65535) mec++;
      end
      mrng = {mrng[14:0], mrng[15] ^ mrng[13] ^ mrng[12] ^ mrng[10]}; // R8
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every cycle, away from the edge
  always @(negedge clk) if (rst_n) begin
    check(phase, clean_req, mpend);
    if (mpend) check(phase, clean_set, mset);
  end

  task automatic cyc(bit ev, int blk, bit done);
    erase_valid = ev; erase_block = 4'(blk); clean_done = done;
    @(negedge clk);
  endtask

  initial begin
    #200000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R1", clean_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", clean_req, 0);

    phase = "R9";
    repeat (20) cyc(0, 0, 0);
    check("R9", clean_req, 0);

    // R4/R2: same set erased four times, ratio met on the fifth edge
    phase = "R4";
    repeat (4) cyc(1, 1, 0);
    check("R4", clean_req, 0);
    cyc(0, 0, 0);
    check("R4", clean_req, 1);
    check("R5", clean_set, 1);
    // R6: held while no done
    repeat (3) cyc(1, 9, 0);
    check("R6", clean_req, 1);
    cyc(0, 0, 1);
    check("R6", clean_req, 0);

    phase = "R5/R6/R7 random";
    for (int n = 0; n < 4000; n++) begin
      bit ev, dn;
      ev = ($urandom % 3) != 0;
      dn = clean_req && (($urandom % 4) == 0);
      cyc(ev, $urandom % NB, dn);
    end
    check("R7 wipe seen", nwipe > 0, 1);
    check("R5 picks seen", nissue > 3, 1);

    phase = "R3 tail";
    repeat (10) cyc(0, 0, clean_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule